// File: doc/BRIEF.md
# Serial Channel-Select Command Register

This block holds the active input-channel code for an eight-way front-end multiplexer that feeds a converter. A host programs a new channel by shifting a short command in on a serial data line. Each bit is captured on a rising edge of the serial clock while the multiplexer select is high and the converter reports that it is asleep. The command is four bits long. The first bit received is an enable flag. The next three bits give the channel number, most significant bit first.

A captured command does not take effect at once. The block holds it until the next falling edge of the multiplexer select. At that edge the block checks it: a complete command with its enable flag set replaces the active channel code, and any other command is dropped. The new code is then used for the first conversion after the data output phase. Clock edges that arrive while the select is low are ignored, as are edges that arrive while the converter is busy. All inputs are treated as synchronous to the block clock. Edges on the serial clock and on the select are found by comparing each input with its value on the previous clock.

Top module: `chan_sel_reg`

## Requirements
- R1: While reset is asserted and directly after it, `chan_sel` is 0.
- R2: After exactly four bits are shifted in (enable bit first, then channel bits 2, 1, 0), with the enable bit equal to 1, a falling edge of `mux_cs_n` sets `chan_sel` to the three channel bits. The new value appears one clock after the edge is seen.
- R3: `chan_sel` changes only on a falling edge of `mux_cs_n`. A captured command leaves it unchanged until that edge.
- R4: A command whose enable bit is 0 leaves `chan_sel` unchanged at the falling edge. This includes data held low for the whole command.
- R5: If fewer than four bits were captured before the falling edge of `mux_cs_n`, the command is discarded and `chan_sel` keeps its value. This includes the case where the serial clock stays low. Each falling edge clears the captured bit count.
- R6: Rising edges of `sclk` while `mux_cs_n` is low have no effect on the selection.
- R7: Rising edges of `sclk` while `asleep` is 0 are not captured.
- R8: Bits after the fourth, up to the next falling edge of `mux_cs_n`, are ignored. The first four bits decide the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| mux_cs_n | input | 1 | Multiplexer select, active low; its falling edge applies a captured command |
| sclk | input | 1 | Serial clock; bits are captured on its rising edges |
| sdi | input | 1 | Serial command data |
| asleep | input | 1 | High while the converter is in its sleep state |
| chan_sel | output | CH_W (3) | Active channel code |

## Verification
A wrong bit count or a wrong shift order shows up at the next falling edge of the select. At that edge `chan_sel` takes a value other than the command's channel bits, or it updates when the command should have been dropped. The error is visible one clock after the edge. Every channel code is sent with the enable bit both high and low. Partial commands, overlong commands, clocks during select-low and clocks while awake are each followed by an edge on the select, so that a wrongly captured bit becomes visible on the output.

// File: rtl/chan_sel_reg.sv
module chan_sel_reg #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mux_cs_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic            asleep,
  output logic [CH_W-1:0] chan_sel
);
  localparam int CMD_W = CH_W + 1;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);

  logic             cs_q, sclk_q;
  logic [CMD_W-1:0] cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  chan_q;

  wire sclk_rise = sclk & ~sclk_q;
  wire cs_fall   = cs_q & ~mux_cs_n;
  wire shift_en  = sclk_rise & mux_cs_n & asleep & (cnt_q != FULL);
  wire take      = cs_fall & (cnt_q == FULL) & cmd_q[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b1;
      cmd_q  <= '0;
      cnt_q  <= '0;
      chan_q <= '0;
    end else begin
      cs_q   <= mux_cs_n;
      sclk_q <= sclk;
      if (cs_fall) begin
        cnt_q <= '0;
        if (take) chan_q <= cmd_q[CH_W-1:0];
      end else if (shift_en) begin
        cmd_q <= {cmd_q[CMD_W-2:0], sdi};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign chan_sel = chan_q;
endmodule

// File: rtl/chan_sel_reg_chk.sv
module chan_sel_reg_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mux_cs_n,
  input logic            sclk,
  input logic            asleep,
  input logic [CH_W-1:0] chan_sel,
  input logic [CH_W:0]   cmd,
  input logic [$clog2(CH_W+2)-1:0] cnt
);
  localparam int CMD_W = CH_W + 1;
  logic cs_d, sclk_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d   <= 1'b0;
      sclk_d <= 1'b1;
    end else begin
      cs_d   <= mux_cs_n;
      sclk_d <= sclk;
    end
  wire cs_fall = cs_d & ~mux_cs_n;

  always @(negedge clk)
    if (!rst_n) p_reset_chan_r1: assert (chan_sel == '0);

  p_only_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(chan_sel));

  p_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && cnt == CMD_W && cmd[CH_W]) |=> (chan_sel == $past(cmd[CH_W-1:0])));

  p_enable_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !cmd[CH_W]) |=> $stable(chan_sel));

  p_short_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && cnt != CMD_W) |=> $stable(chan_sel));

  p_low_cs_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_cs_n && sclk && !sclk_d) |=> $stable(cnt));

  p_awake_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && mux_cs_n) |=> $stable(cnt));

  p_count_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CMD_W));
endmodule

bind chan_sel_reg chan_sel_reg_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_cs_n(mux_cs_n), .sclk(sclk),
  .asleep(asleep), .chan_sel(chan_sel), .cmd(cmd_q), .cnt(cnt_q)
);

// File: tb/chan_sel_reg_test.sv
module chan_sel_reg_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, asleep = 1'b1;
  logic [2:0] chan_sel;
  int checks = 0, failures = 0;
  logic [2:0] exp_ch = 3'd0;

  always #4 clk = ~clk;

  chan_sel_reg uut (.clk(clk), .rst_n(rst_n), .mux_cs_n(mux_cs_n), .sclk(sclk),
                    .sdi(sdi), .asleep(asleep), .chan_sel(chan_sel));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s chan_sel=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdi = bits[i]; sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic fall_and_check(input string req);
    @(negedge clk); mux_cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(req, chan_sel, exp_ch);
    mux_cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", chan_sel, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", chan_sel, 3'd0);

    // R2 / R3: every channel with enable set
    for (int c = 0; c < 8; c++) begin
      logic [2:0] ch = 3'(7 - c);
      shift_bits({4'b0, 1'b1, ch}, 4);
      repeat (2) @(negedge clk);
      check("R3", chan_sel, exp_ch);
      exp_ch = ch;
      fall_and_check("R2");
    end

    // R4: enable low for every channel, including all-zero data
    for (int c = 0; c < 8; c++) begin
      shift_bits({4'b0, 1'b0, 3'(c)}, 4);
      fall_and_check("R4");
    end

    // R5: partial commands of 0..3 bits
    for (int n = 0; n < 4; n++) begin
      shift_bits(8'b0000_1101, n);
      fall_and_check("R5");
    end
    shift_bits(8'b0000_0111, 3);
    fall_and_check("R5");
    shift_bits(8'b0000_0001, 1);
    fall_and_check("R5");

    // R6: clocks while select is low
    @(negedge clk); mux_cs_n = 1'b0;
    shift_bits(8'b0000_1010, 4);
    @(negedge clk); mux_cs_n = 1'b1;
    fall_and_check("R6");

    // R7: clocks while converter is awake
    asleep = 1'b0;
    shift_bits(8'b0000_1100, 4);
    asleep = 1'b1;
    fall_and_check("R7");
    asleep = 1'b0;
    shift_bits(8'b0000_1110, 2);
    asleep = 1'b1;
    shift_bits(8'b0000_0011, 2);
    fall_and_check("R7");

    // R8: extra bits after the fourth ignored
    for (int c = 0; c < 8; c++) begin
      logic [2:0] ch = 3'(c);
      shift_bits({2'b0, 1'b1, ch, 2'(c)}, 6);
      exp_ch = ch;
      fall_and_check("R8");
    end
    shift_bits({2'b0, 1'b0, 3'd5, 2'b11}, 6);
    fall_and_check("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule